// File: doc/BRIEF.md
# Vectorised Compare-to-Predicate Unit

This block takes a conditional-branch instruction, 32-bit or 16-bit compressed, whose source operands name a vectorised register. It does not branch. It steps through the vector one element per cycle, compares each pair of source elements, and writes the result of element i into bit i of a predicate register. The offset bits of the branch are reinterpreted as the index of the target register. The block also handles single-precision float compares (equal, less-than, less-or-equal). When such a compare writes an integer register tagged as a predicate, the result goes to the bit of each element. When the register is not tagged, the register receives a plain 0 or 1.

The surrounding pipeline pulses `start` with the instruction, the vector length and three tag vectors. It then supplies element operands combinationally for the register numbers and element index the block drives out. Each predicate update leaves the block as a one-bit masked write, so the register file changes exactly one bit per cycle. `done` marks the end of each accepted instruction.

Top module: `vpred_cmp_unit`

## Requirements
- R1: A 32-bit branch (opcode 1100011) with a vectorised source (rs1 = bits 19:15, rs2 = bits 24:20) and funct3 000/001/100/101 performs, for every element, EQ / NE / signed LT / signed GE of rs1 against rs2. It writes bit e of the integer register named by bits 11:7, and each write sets exactly one mask bit.
- R2: In the 32-bit predicated form, a nonzero value in bits 31:25 raises `illegal` together with `done` in the cycle after `start`, and produces no write.
- R3: A compressed instruction (bits 1:0 = 01, funct3 in bits 15:13 = 110 or 111) uses bits 9:7 for src1, bits 4:2 for src2 and bits 12:10 for the target. Each 3-bit field n names register 8+n.
- R4: In compressed form, the pair {funct3[0], bit 5} selects 00 EQ, 10 NE, 01 LT, 11 LE. Bit 6 = 1 makes both sources float registers and the compare a float compare. Bit 6 = 0 selects integer registers and a signed compare.
- R5: Float compares are single precision. +0 and -0 are equal. EQ, LT and LE are false when either operand is NaN, and NE is the complement of EQ.
- R6: A float compare (opcode 1010011, bits 31:25 = 1010000, funct3 010 EQ / 001 LT / 000 LE) whose rd (bits 11:7) is tagged in `pred_tag` writes one predicate bit per element into rd.
- R7: The same float compare with an untagged rd makes a single integer write of 0 or 1 to rd. The write uses element 0 and comes two cycles after `start`.
- R8: Elements are handled in ascending order from 0, one per cycle. The write of element vl-1 comes with `done`, vl+1 cycles after `start`.
- R9: Predicate bits at or above the effective vector length are never written. A length above MAX_VL is clamped to MAX_VL. A length of 0 gives `done` one cycle after `start` with no write.
- R10: A branch with no vectorised source, or with an unsupported funct3, ends with `done`, without `illegal` and without any write.
- R11: A `start` while `busy` is high is ignored. It produces no writes and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid, taken when not busy |
| instr | input | 32 | Instruction word (compressed in bits 15:0) |
| vec_len | input | VL_IN_W | Requested vector length |
| int_vec_tag | input | 32 | Integer registers marked vectorised |
| fp_vec_tag | input | 32 | Float registers marked vectorised |
| pred_tag | input | 32 | Integer registers marked as predicate registers |
| busy | output | 1 | Element loop in progress |
| rd_elem | output | IDXW | Element index being compared |
| rd_reg_a | output | 5 | First operand register |
| rd_reg_b | output | 5 | Second operand register |
| rd_fp | output | 1 | Operands come from the float register file |
| op_a | input | 32 | Element value of rd_reg_a |
| op_b | input | 32 | Element value of rd_reg_b |
| pw_valid | output | 1 | Predicate bit write |
| pw_reg | output | 5 | Predicate register index |
| pw_mask | output | MAX_VL | One-hot bit select |
| pw_bits | output | MAX_VL | Bit value under the mask |
| iw_valid | output | 1 | Whole-register integer write |
| iw_reg | output | 5 | Integer destination |
| iw_data | output | 32 | Value 0 or 1 |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Reserved bits were set |

## Verification
Integer operands mix negative and positive values with repeated equal pairs. This separates signed from unsigned ordering and LT from LE, and shows whether GE comes from swapping the operands. Float operands include +0/-0 pairs, NaN against NaN and NaN against numbers, and numbers of both signs. These patterns show zero folding, NaN handling and the complement rule for NE. The predicate register starts from a non-zero pattern, and lengths of 0, 17, 20 and 40 are used, so bits left untouched above the length and the clamp become visible. A second `start` is injected mid-run to show that requests arriving while busy are dropped.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    localparam int XLEN = 32;
    localparam int REGW = 5;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_OPFP   = 7'b1010011;
    localparam logic [6:0] F7_FCMP_S  = 7'b1010000;

    typedef enum logic [1:0] {
        CMP_EQ,
        CMP_NE,
        CMP_LT,
        CMP_LE
    } cmp_op_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_PRED,
        KIND_SCALAR,
        KIND_ILLEGAL
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        cmp_op_e         op;
        logic            is_fp;
        logic [REGW-1:0] src_a;
        logic [REGW-1:0] src_b;
        logic [REGW-1:0] dst;
    } dec_t;
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
    import vpc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic [31:0]     int_vec_tag,
    input  logic [31:0]     fp_vec_tag,
    input  logic [31:0]     pred_tag,
    output dec_t            dec
);
    logic [2:0]      f3;
    logic [REGW-1:0] r1, r2, rd, c1, c2, cd;
    logic            ok, swap, c_fp, c_vec;
    cmp_op_e         op;

    always_comb begin
        dec       = '0;
        dec.kind  = KIND_NONE;
        dec.op    = CMP_EQ;
        f3        = instr[14:12];
        r1        = instr[19:15];
        r2        = instr[24:20];
        rd        = instr[11:7];
        c1        = {2'b01, instr[9:7]};
        c2        = {2'b01, instr[4:2]};
        cd        = {2'b01, instr[12:10]};
        c_fp      = instr[6];
        c_vec     = c_fp ? (fp_vec_tag[c1] | fp_vec_tag[c2])
                         : (int_vec_tag[c1] | int_vec_tag[c2]);
        ok        = 1'b1;
        swap      = 1'b0;
        op        = CMP_EQ;

        if (instr[1:0] == 2'b11) begin
            if (instr[6:0] == OPC_BRANCH) begin
                case (f3)
                    3'b000:  op = CMP_EQ;
                    3'b001:  op = CMP_NE;
                    3'b100:  op = CMP_LT;
                    3'b101: begin
                        op   = CMP_LE;   // a >= b  ==  b <= a
                        swap = 1'b1;
                    end
                    default: ok = 1'b0;
                endcase
                if (ok && (int_vec_tag[r1] | int_vec_tag[r2])) begin
                    dec.kind  = (instr[31:25] != 7'd0) ? KIND_ILLEGAL : KIND_PRED;
                    dec.op    = op;
                    dec.is_fp = 1'b0;
                    dec.src_a = swap ? r2 : r1;
                    dec.src_b = swap ? r1 : r2;
                    dec.dst   = rd;
                end
            end else if (instr[6:0] == OPC_OPFP && instr[31:25] == F7_FCMP_S) begin
                case (f3)
                    3'b010:  op = CMP_EQ;
                    3'b001:  op = CMP_LT;
                    3'b000:  op = CMP_LE;
                    default: ok = 1'b0;
                endcase
                if (ok) begin
                    dec.kind  = pred_tag[rd] ? KIND_PRED : KIND_SCALAR;
                    dec.op    = op;
                    dec.is_fp = 1'b1;
                    dec.src_a = r1;
                    dec.src_b = r2;
                    dec.dst   = rd;
                end
            end
        end else if (instr[1:0] == 2'b01 && instr[15:14] == 2'b11) begin
            case ({instr[13], instr[5]})
                2'b00:   op = CMP_EQ;
                2'b10:   op = CMP_NE;
                2'b01:   op = CMP_LT;
                default: op = CMP_LE;
            endcase
            if (c_vec) begin
                dec.kind  = KIND_PRED;
                dec.op    = op;
                dec.is_fp = c_fp;
                dec.src_a = c1;
                dec.src_b = c2;
                dec.dst   = cd;
            end
        end
    end
endmodule

// File: rtl/vpc_elem_cmp.sv
module vpc_elem_cmp
    import vpc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_fp,
    input  cmp_op_e         op,
    output logic            hit
);
    logic a_nan, b_nan, any_nan, both_zero;
    logic f_eq, f_lt, i_eq, i_lt, eq, lt;

    always_comb begin
        a_nan     = (&a[30:23]) && (|a[22:0]);
        b_nan     = (&b[30:23]) && (|b[22:0]);
        any_nan   = a_nan | b_nan;
        both_zero = (a[30:0] == 31'd0) && (b[30:0] == 31'd0);
        f_eq      = !any_nan && ((a == b) || both_zero);
        if (a[31] != b[31])
            f_lt = a[31];
        else if (a[31])
            f_lt = a[30:0] > b[30:0];
        else
            f_lt = a[30:0] < b[30:0];
        f_lt      = f_lt && !any_nan && !both_zero;
        i_eq      = (a == b);
        i_lt      = $signed(a) < $signed(b);
        eq        = is_fp ? f_eq : i_eq;
        lt        = is_fp ? f_lt : i_lt;
        case (op)
            CMP_EQ:  hit = eq;
            CMP_NE:  hit = !eq;
            CMP_LT:  hit = lt;
            default: hit = lt | eq;
        endcase
    end
endmodule

// File: rtl/vpred_cmp_unit.sv
module vpred_cmp_unit
    import vpc_pkg::*;
#(
    parameter int MAX_VL  = 32,
    parameter int VL_IN_W = 8,
    localparam int IDXW   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        instr,
    input  logic [VL_IN_W-1:0] vec_len,
    input  logic [31:0]        int_vec_tag,
    input  logic [31:0]        fp_vec_tag,
    input  logic [31:0]        pred_tag,
    output logic               busy,
    output logic [IDXW-1:0]    rd_elem,
    output logic [4:0]         rd_reg_a,
    output logic [4:0]         rd_reg_b,
    output logic               rd_fp,
    input  logic [31:0]        op_a,
    input  logic [31:0]        op_b,
    output logic               pw_valid,
    output logic [4:0]         pw_reg,
    output logic [MAX_VL-1:0]  pw_mask,
    output logic [MAX_VL-1:0]  pw_bits,
    output logic               iw_valid,
    output logic [4:0]         iw_reg,
    output logic [31:0]        iw_data,
    output logic               done,
    output logic               illegal
);
    typedef struct packed {
        logic              busy;
        logic              scalar;
        cmp_op_e           op;
        logic              is_fp;
        logic [REGW-1:0]   ra;
        logic [REGW-1:0]   rb;
        logic [REGW-1:0]   dst;
        logic [IDXW-1:0]   idx;
        logic [IDXW-1:0]   last;
        logic              pw_valid;
        logic [REGW-1:0]   pw_reg;
        logic [MAX_VL-1:0] pw_mask;
        logic [MAX_VL-1:0] pw_bits;
        logic              iw_valid;
        logic [REGW-1:0]   iw_reg;
        logic              iw_bit;
        logic              done;
        logic              illegal;
    } st_t;

    st_t                st_d, st_q;
    dec_t               dec;
    logic               hit;
    logic [VL_IN_W-1:0] vl_eff;

    vpc_decode u_dec (
        .instr       (instr),
        .int_vec_tag (int_vec_tag),
        .fp_vec_tag  (fp_vec_tag),
        .pred_tag    (pred_tag),
        .dec         (dec)
    );

    vpc_elem_cmp u_cmp (
        .a     (op_a),
        .b     (op_b),
        .is_fp (st_q.is_fp),
        .op    (st_q.op),
        .hit   (hit)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pw_valid = 1'b0;
        st_d.iw_valid = 1'b0;
        st_d.done     = 1'b0;
        st_d.illegal  = 1'b0;
        vl_eff        = (vec_len > VL_IN_W'(MAX_VL)) ? VL_IN_W'(MAX_VL) : vec_len;

        if (!st_q.busy) begin
            if (start) begin
                st_d.op    = dec.op;
                st_d.is_fp = dec.is_fp;
                st_d.ra    = dec.src_a;
                st_d.rb    = dec.src_b;
                st_d.dst   = dec.dst;
                st_d.idx   = '0;
                case (dec.kind)
                    KIND_ILLEGAL: begin
                        st_d.done    = 1'b1;
                        st_d.illegal = 1'b1;
                    end
                    KIND_SCALAR: begin
                        st_d.busy   = 1'b1;
                        st_d.scalar = 1'b1;
                        st_d.last   = '0;
                    end
                    KIND_PRED: begin
                        st_d.scalar = 1'b0;
                        st_d.last   = IDXW'(vl_eff - 1'b1);
                        if (vl_eff == '0)
                            st_d.done = 1'b1;
                        else
                            st_d.busy = 1'b1;
                    end
                    default: st_d.done = 1'b1;
                endcase
            end
        end else begin
            if (st_q.scalar) begin
                st_d.iw_valid = 1'b1;
                st_d.iw_reg   = st_q.dst;
                st_d.iw_bit   = hit;
            end else begin
                st_d.pw_valid = 1'b1;
                st_d.pw_reg   = st_q.dst;
                st_d.pw_mask  = MAX_VL'(1) << st_q.idx;
                st_d.pw_bits  = MAX_VL'(hit) << st_q.idx;
            end
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign rd_elem  = st_q.idx;
    assign rd_reg_a = st_q.ra;
    assign rd_reg_b = st_q.rb;
    assign rd_fp    = st_q.is_fp;
    assign pw_valid = st_q.pw_valid;
    assign pw_reg   = st_q.pw_reg;
    assign pw_mask  = st_q.pw_mask;
    assign pw_bits  = st_q.pw_bits;
    assign iw_valid = st_q.iw_valid;
    assign iw_reg   = st_q.iw_reg;
    assign iw_data  = {31'd0, st_q.iw_bit};
    assign done     = st_q.done;
    assign illegal  = st_q.illegal;
endmodule

// File: rtl/vpred_cmp_unit_chk.sv
module vpred_cmp_unit_chk #(
    parameter int MAX_VL  = 32,
    parameter int IDXW    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [IDXW-1:0]   rd_elem,
    input logic              pw_valid,
    input logic [MAX_VL-1:0] pw_mask,
    input logic [MAX_VL-1:0] pw_bits,
    input logic              iw_valid,
    input logic [31:0]       iw_data,
    input logic              done,
    input logic              illegal
);
    p_one_mask_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> $countones(pw_mask) == 1);

    p_bits_under_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> (pw_bits & ~pw_mask) == '0);

    p_illegal_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !pw_valid && !iw_valid));

    p_scalar_is_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iw_valid |-> iw_data[31:1] == 31'd0);

    p_first_elem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rd_elem == '0);

    p_elem_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> rd_elem == IDXW'($past(rd_elem) + 1'b1));

    p_no_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !pw_valid && !iw_valid);
endmodule

bind vpred_cmp_unit vpred_cmp_unit_chk #(.MAX_VL(MAX_VL), .IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rd_elem  (rd_elem),
    .pw_valid (pw_valid),
    .pw_mask  (pw_mask),
    .pw_bits  (pw_bits),
    .iw_valid (iw_valid),
    .iw_data  (iw_data),
    .done     (done),
    .illegal  (illegal)
);

// File: tb/vpred_cmp_unit_bench.sv
`timescale 1ns/1ps
module vpred_cmp_unit_bench;
    localparam int MAX_VL  = 32;
    localparam int VL_IN_W = 8;
    localparam int IDXW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               start = 1'b0;
    logic [31:0]        instr = '0;
    logic [VL_IN_W-1:0] vec_len = '0;
    logic [31:0]        int_vec_tag = '0, fp_vec_tag = '0, pred_tag = '0;
    logic               busy, rd_fp, pw_valid, iw_valid, done, illegal;
    logic [IDXW-1:0]    rd_elem;
    logic [4:0]         rd_reg_a, rd_reg_b, pw_reg, iw_reg;
    logic [31:0]        op_a, op_b, iw_data;
    logic [MAX_VL-1:0]  pw_mask, pw_bits;

    logic [31:0] ia [32][MAX_VL];
    logic [31:0] fa [32][MAX_VL];

    always_comb begin
        op_a = rd_fp ? fa[rd_reg_a][rd_elem] : ia[rd_reg_a][rd_elem];
        op_b = rd_fp ? fa[rd_reg_b][rd_elem] : ia[rd_reg_b][rd_elem];
    end

    vpred_cmp_unit #(.MAX_VL(MAX_VL), .VL_IN_W(VL_IN_W)) u_vpred_cmp_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .vec_len(vec_len),
        .int_vec_tag(int_vec_tag), .fp_vec_tag(fp_vec_tag), .pred_tag(pred_tag),
        .busy(busy), .rd_elem(rd_elem), .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b),
        .rd_fp(rd_fp), .op_a(op_a), .op_b(op_b), .pw_valid(pw_valid), .pw_reg(pw_reg),
        .pw_mask(pw_mask), .pw_bits(pw_bits), .iw_valid(iw_valid), .iw_reg(iw_reg),
        .iw_data(iw_data), .done(done), .illegal(illegal)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- encoders ----------------
    function automatic logic [31:0] enc_b32(input logic [6:0] res, input logic [4:0] s2,
                                            input logic [4:0] s1, input logic [2:0] f3,
                                            input logic [4:0] pd);
        return {res, s2, s1, f3, pd, 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_c(input logic [2:0] f3, input logic [2:0] pd,
                                          input logic [2:0] s1, input logic fp,
                                          input logic b5, input logic [2:0] s2);
        return {16'h0, f3, pd, s1, fp, b5, s2, 2'b01};
    endfunction

    function automatic logic [31:0] enc_f(input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [4:0] s1, input logic [4:0] s2);
        return {7'b1010000, s2, s1, f3, rd, 7'b1010011};
    endfunction

    // ---------------- reference model ----------------
    // op: 0 EQ, 1 NE, 2 LT, 3 LE, 5 GE
    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction

    function automatic logic [31:0] fkey(input logic [31:0] x);
        if (x[30:0] == 0) return 32'h8000_0000;
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic bit ref_cmp(input int op, input bit fp,
                                   input logic [31:0] a, input logic [31:0] b);
        logic [31:0] ka, kb;
        if (fp) begin
            if (is_nan(a) || is_nan(b)) return (op == 1);
            ka = fkey(a); kb = fkey(b);
            case (op)
                0: return ka == kb;
                1: return ka != kb;
                2: return ka < kb;
                3: return ka <= kb;
                default: return ka >= kb;
            endcase
        end
        case (op)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) < $signed(b);
            3: return $signed(a) <= $signed(b);
            default: return $signed(a) >= $signed(b);
        endcase
    endfunction

    function automatic logic [31:0] ref_vec(input int op, input bit fp, input int ra,
                                            input int rb, input int vl, input logic [31:0] init);
        logic [31:0] r = init;
        for (int e = 0; e < vl && e < MAX_VL; e++)
            r[e] = fp ? ref_cmp(op, 1, fa[ra][e], fa[rb][e])
                      : ref_cmp(op, 0, ia[ra][e], ia[rb][e]);
        return r;
    endfunction

    // ---------------- driver / collector ----------------
    logic [31:0] acc, iw_d;
    logic [4:0]  iw_r;
    int          ncyc, nwr, iw_cnt;
    bit          got_ill, bad_reg;

    task automatic run(input logic [31:0] ins, input int vl, input logic [31:0] init,
                       input logic [4:0] exp_reg, input logic [31:0] intrude);
        @(negedge clk);
        instr = ins; vec_len = VL_IN_W'(vl); start = 1'b1;
        acc = init; ncyc = 0; nwr = 0; iw_cnt = 0; got_ill = 0; bad_reg = 0;
        iw_d = '0; iw_r = '0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 200; k++) begin
            ncyc++;
            if (pw_valid) begin
                acc = (acc & ~pw_mask) | (pw_bits & pw_mask);
                nwr++;
                if (pw_reg !== exp_reg) bad_reg = 1;
            end
            if (iw_valid) begin iw_cnt++; iw_d = iw_data; iw_r = iw_reg; end
            if (illegal) got_ill = 1;
            if (done) break;
            if (k == 1 && intrude != 0) begin start = 1'b1; instr = intrude; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check_eq("R8", "reset busy", {31'd0, busy}, 32'd0);
        check_eq("R8", "reset done", {31'd0, done}, 32'd0);
        check_eq("R1", "reset pw_valid", {31'd0, pw_valid}, 32'd0);
        check_eq("R2", "reset illegal", {31'd0, illegal}, 32'd0);
    endtask

    task automatic t_branch32();
        logic [2:0] f3s [4] = '{3'b000, 3'b001, 3'b100, 3'b101};
        int ops [4] = '{0, 1, 2, 5};
        int_vec_tag = 32'h0000_0060;
        for (int i = 0; i < 4; i++) begin
            run(enc_b32(7'd0, 5'd6, 5'd5, f3s[i], 5'd12), 20, 32'hDEAD_BEEF, 5'd12, 0);
            check_eq("R1", $sformatf("branch f3=%b predicate", f3s[i]), acc,
                     ref_vec(ops[i], 0, 5, 6, 20, 32'hDEAD_BEEF));
            check_eq("R1", "branch target register", {31'd0, bad_reg}, 32'd0);
            check_eq("R8", "branch latency", ncyc, 21);
        end
    endtask

    task automatic t_reserved();
        int_vec_tag = 32'h0000_0060;
        run(enc_b32(7'h10, 5'd6, 5'd5, 3'b000, 5'd12), 20, 32'h1234_5678, 5'd12, 0);
        check_eq("R2", "reserved illegal", {31'd0, got_ill}, 32'd1);
        check_eq("R2", "reserved no write", nwr, 0);
        check_eq("R2", "reserved latency", ncyc, 1);
    endtask

    task automatic t_compressed_int();
        int_vec_tag = 32'h0000_0200;
        for (int s = 0; s < 4; s++) begin
            logic f0 = s[1];
            logic b5 = s[0];
            int op = (!f0 && !b5) ? 0 : (f0 && !b5) ? 1 : (!f0 && b5) ? 2 : 3;
            run(enc_c({2'b11, f0}, 3'd3, 3'd1, 1'b0, b5, 3'd2), 17, 32'hF0F0_0F0F, 5'd11, 0);
            check_eq("R3", $sformatf("compressed int sel=%0d", s), acc,
                     ref_vec(op, 0, 9, 10, 17, 32'hF0F0_0F0F));
            check_eq("R4", "compressed int target x11", {31'd0, bad_reg}, 32'd0);
        end
    endtask

    task automatic t_compressed_fp();
        int_vec_tag = '0;
        fp_vec_tag  = 32'h0000_0400;
        for (int s = 0; s < 4; s++) begin
            logic f0 = s[1];
            logic b5 = s[0];
            int op = (!f0 && !b5) ? 0 : (f0 && !b5) ? 1 : (!f0 && b5) ? 2 : 3;
            run(enc_c({2'b11, f0}, 3'd3, 3'd1, 1'b1, b5, 3'd2), 24, 32'h0, 5'd11, 0);
            check_eq("R5", $sformatf("compressed float sel=%0d", s), acc,
                     ref_vec(op, 1, 9, 10, 24, 32'h0));
        end
        fp_vec_tag = '0;
    endtask

    task automatic t_fcmp_tagged();
        logic [2:0] f3s [3] = '{3'b010, 3'b001, 3'b000};
        int ops [3] = '{0, 2, 3};
        pred_tag = 32'h0000_0080;
        for (int i = 0; i < 3; i++) begin
            run(enc_f(f3s[i], 5'd7, 5'd9, 5'd10), 16, 32'hAAAA_5555, 5'd7, 0);
            check_eq("R6", $sformatf("tagged fcmp f3=%b", f3s[i]), acc,
                     ref_vec(ops[i], 1, 9, 10, 16, 32'hAAAA_5555));
            check_eq("R6", "tagged fcmp no int write", iw_cnt, 0);
        end
        pred_tag = '0;
    endtask

    task automatic t_fcmp_scalar();
        run(enc_f(3'b010, 5'd7, 5'd9, 5'd10), 16, 32'h0, 5'd7, 0);
        check_eq("R7", "FEQ scalar value", iw_d, {31'd0, ref_cmp(0, 1, fa[9][0], fa[10][0])});
        check_eq("R7", "FEQ scalar reg", {27'd0, iw_r}, 32'd7);
        check_eq("R7", "FEQ scalar one write", iw_cnt, 1);
        check_eq("R7", "FEQ scalar no predicate", nwr, 0);
        check_eq("R7", "FEQ scalar latency", ncyc, 2);
        run(enc_f(3'b001, 5'd7, 5'd9, 5'd10), 16, 32'h0, 5'd7, 0);
        check_eq("R7", "FLT scalar value", iw_d, {31'd0, ref_cmp(2, 1, fa[9][0], fa[10][0])});
    endtask

    task automatic t_lengths();
        int_vec_tag = 32'h0000_0060;
        run(enc_b32(7'd0, 5'd6, 5'd5, 3'b100, 5'd12), 0, 32'h5A5A_5A5A, 5'd12, 0);
        check_eq("R9", "vl=0 no write", nwr, 0);
        check_eq("R9", "vl=0 latency", ncyc, 1);
        check_eq("R9", "vl=0 register intact", acc, 32'h5A5A_5A5A);
        run(enc_b32(7'd0, 5'd6, 5'd5, 3'b100, 5'd12), 40, 32'h5A5A_5A5A, 5'd12, 0);
        check_eq("R9", "vl=40 clamped result", acc, ref_vec(2, 0, 5, 6, 32, 32'h0));
        check_eq("R9", "vl=40 clamped latency", ncyc, MAX_VL + 1);
    endtask

    task automatic t_not_vector();
        int_vec_tag = '0;
        run(enc_b32(7'd0, 5'd6, 5'd5, 3'b000, 5'd12), 20, 32'h0, 5'd12, 0);
        check_eq("R10", "scalar branch no write", nwr, 0);
        check_eq("R10", "scalar branch not illegal", {31'd0, got_ill}, 32'd0);
        check_eq("R10", "scalar branch done", ncyc, 1);
        int_vec_tag = 32'h0000_0060;
        run(enc_b32(7'd0, 5'd6, 5'd5, 3'b110, 5'd12), 20, 32'h0, 5'd12, 0);
        check_eq("R10", "unsupported funct3 no write", nwr, 0);
        check_eq("R10", "unsupported funct3 done", ncyc, 1);
    endtask

    task automatic t_busy_ignore();
        int extra = 0;
        int_vec_tag = 32'h0000_0060;
        run(enc_b32(7'd0, 5'd6, 5'd5, 3'b001, 5'd12), 10, 32'h0,
            5'd12, enc_b32(7'd0, 5'd5, 5'd6, 3'b000, 5'd13));
        check_eq("R11", "busy start result", acc, ref_vec(1, 0, 5, 6, 10, 32'h0));
        check_eq("R11", "busy start target", {31'd0, bad_reg}, 32'd0);
        check_eq("R11", "busy start writes", nwr, 10);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done || pw_valid) extra++;
        end
        check_eq("R11", "no later activity", extra, 0);
    endtask

    // ---------------- data and sequence ----------------
    initial begin
        logic [31:0] ft [8] = '{32'h3f80_0000, 32'hbf80_0000, 32'h0000_0000, 32'h8000_0000,
                                32'h7fc0_0000, 32'h4000_0000, 32'hc000_0000, 32'h3f80_0000};
        for (int r = 0; r < 32; r++)
            for (int e = 0; e < MAX_VL; e++) begin
                ia[r][e] = 32'(r * 7 + e);
                fa[r][e] = ft[(r + e) % 8];
            end
        for (int e = 0; e < MAX_VL; e++) begin
            ia[5][e]  = 32'(e - 10);
            ia[6][e]  = (e % 4 == 0) ? 32'(e - 10) : 32'(3 - (e % 7));
            ia[9][e]  = ia[5][e];
            ia[10][e] = ia[6][e];
            fa[9][e]  = ft[e % 8];
            fa[10][e] = ft[(e + e / 8) % 8];
        end
        fa[9][0] = 32'h3f80_0000;
        fa[10][0] = 32'h3f80_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_branch32();
        t_reserved();
        t_compressed_int();
        t_compressed_fp();
        t_fcmp_tagged();
        t_fcmp_scalar();
        t_lengths();
        t_not_vector();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule